// File: doc/BRIEF.md
# Adaptive Dead-Time Half-Bridge Gate Sequencer

This block turns one PWM command into two gate enables for a synchronous buck half-bridge: one for the high-side switch and one for the low-side switch. It never uses a fixed dead time. Before it turns either switch on, it waits for an analog comparator to report that the opposite switch has really turned off. For the low-side switch, that report is its gate voltage falling below its threshold. For the high-side switch, it is the switch node falling below its threshold.

Two timers protect the bootstrap supply and the power stage:

- **Forced turn-on.** If the switch node does not fall in time after the high side turns off, the low side is turned on anyway, so the bootstrap capacitor keeps its charge.
- **Stuck-high fault.** If the switch node then stays high for too long while the low side is on, both gates are parked off and a sticky fault is raised. The park lasts until the next PWM rising edge.

A hysteretic supply-good condition gates all switching, and so does a shutdown request. Every asynchronous input passes through a two-stage synchronizer. Both timer windows are given in nanoseconds and converted to cycles from the clock frequency parameter. The defaults (100 MHz clock, 250 ns forced turn-on, 2000 ns stuck limit) give 25 and 200 cycles.

Top module: `halfbridge_deadtime_seq`

## Requirements
- R1: After reset, `hs_gate_en`, `ls_gate_en` and `stuck_fault` are all 0.
- R2: `hs_gate_en` and `ls_gate_en` are never 1 in the same cycle.
- R3: When PWM rises, `ls_gate_en` drops first. `hs_gate_en` rises three cycles after `lg_low_in` (1 = low-side gate below its threshold) goes to 1, and it stays 0 while `lg_low_in` is 0.
- R4: When PWM falls, `hs_gate_en` drops first. `ls_gate_en` rises three cycles after `sw_low_in` (1 = switch node below its threshold) goes to 1, provided this is earlier than the forced turn-on.
- R5: If `sw_low_in` stays 0, `ls_gate_en` rises exactly FORCE cycles after `hs_gate_en` falls (25 by default).
- R6: While the low side is on, `sw_low_in` at 0 for STUCK consecutive synchronized cycles (200 by default) drops `ls_gate_en` and sets `stuck_fault` in the same cycle. Any synchronized 1 on `sw_low_in` restarts that count.
- R7: After a stuck fault, both gates stay 0 and changes on `sw_low_in` have no effect. The next PWM rising edge clears `stuck_fault` three cycles after the input edge and resumes switching.
- R8: Supply-good starts at 0 and holds both gates at 0. A 1 on `vcc_rise_in` sets it. A 1 on `vcc_fall_in` clears it, and the fall flag wins if both are 1. While both flags are 0, supply-good keeps its value.
- R9: While `shdn_in` is 1, both gates are forced to 0. After release, switching resumes from the current PWM level.
- R10: Each input passes two synchronizer flops, so a PWM edge changes the gate enables three clock edges after the input change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | 1 | Qualified PWM command (1 = high side wanted) |
| shdn_in | input | 1 | Shutdown request, 1 = force both gates off |
| vcc_rise_in | input | 1 | 1 = bias supply above rising threshold |
| vcc_fall_in | input | 1 | 1 = bias supply below falling threshold |
| lg_low_in | input | 1 | 1 = low-side gate voltage below its threshold |
| sw_low_in | input | 1 | 1 = switch-node voltage below its threshold |
| hs_gate_en | output | 1 | High-side gate enable (registered) |
| ls_gate_en | output | 1 | Low-side gate enable (registered) |
| stuck_fault | output | 1 | Sticky switch-node-stuck-high fault |

## Verification
A corrupted sequencer state shows up at the gate enables within one cycle.

- **Wrong turn-on state.** Both enables high at once, or a high-side enable that rises while the low-side gate flag is 0, appears on the cycle the state is entered.
- **Wrong timer state.** An off-by-one or stale count moves the forced low-side turn-on or the stuck-high park by exactly that many cycles. The bench measures each window edge to the cycle.
- **Lost fault or park state.** A lost park either re-enables a gate before the next PWM rising edge, or leaves the fault flag set after that edge clears it, within three cycles of the edge.

// File: rtl/hbs_pkg.sv
package hbs_pkg;

  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_HS_WAIT = 3'd1,
    ST_HS_ON   = 3'd2,
    ST_LS_WAIT = 3'd3,
    ST_LS_ON   = 3'd4,
    ST_PARK    = 3'd5
  } hbs_state_t;

  // bit positions inside the synchronized input bundle
  localparam int IDX_PWM   = 0;
  localparam int IDX_SHDN  = 1;
  localparam int IDX_VRISE = 2;
  localparam int IDX_VFALL = 3;
  localparam int IDX_LGLOW = 4;
  localparam int IDX_SWLOW = 5;
  localparam int NUM_IN    = 6;

  function automatic int unsigned ns_to_cycles(input int unsigned mhz,
                                               input int unsigned ns);
    int unsigned c;
    c = (mhz * ns + 999) / 1000;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/hbs_sync.sv
module hbs_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
    end else begin
      chain_q[0] <= d;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/hbs_supply_mon.sv
module hbs_supply_mon (
  input  logic clk,
  input  logic rst,
  input  logic rise_s,
  input  logic fall_s,
  output logic good_q
);
  always_ff @(posedge clk) begin
    if (rst)         good_q <= 1'b0;
    else if (fall_s) good_q <= 1'b0;
    else if (rise_s) good_q <= 1'b1;
  end
endmodule

// File: rtl/hbs_interval_cnt.sv
module hbs_interval_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst || clr)              cnt <= '0;
    else if (en && cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/hbs_fsm.sv
module hbs_fsm
  import hbs_pkg::*;
#(
  parameter int FORCE_CYC = 25,
  parameter int STUCK_CYC = 200,
  parameter int CNT_W     = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic pwm_s,
  input  logic lg_low_s,
  input  logic sw_low_s,
  output logic hs_q,
  output logic ls_q,
  output logic fault_q
);
  localparam logic [CNT_W-1:0] FORCE_LAST = CNT_W'(FORCE_CYC - 1);
  localparam logic [CNT_W-1:0] STUCK_LAST = CNT_W'(STUCK_CYC - 1);

  hbs_state_t       state_q, state_d;
  logic             pwm_q;
  logic             pwm_rise;
  logic             cnt_clr, cnt_en;
  logic [CNT_W-1:0] cnt;

  assign pwm_rise = pwm_s & ~pwm_q;

  hbs_interval_cnt #(.W(CNT_W)) win_cnt_i (
    .clk(clk), .rst(rst), .clr(cnt_clr), .en(cnt_en), .cnt(cnt)
  );

  always_comb begin
    state_d = state_q;
    cnt_clr = 1'b1;
    cnt_en  = 1'b0;
    if (!enable) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF: begin
          if (pwm_rise)     state_d = ST_HS_WAIT;
          else if (fault_q) state_d = ST_PARK;
          else if (pwm_s)   state_d = ST_HS_WAIT;
          else              state_d = ST_LS_WAIT;
        end
        ST_HS_WAIT: begin
          if (!pwm_s)        state_d = ST_LS_WAIT;
          else if (lg_low_s) state_d = ST_HS_ON;
        end
        ST_HS_ON: begin
          if (!pwm_s) state_d = ST_LS_WAIT;
        end
        ST_LS_WAIT: begin
          if (pwm_s)                  state_d = ST_HS_WAIT;
          else if (sw_low_s)          state_d = ST_LS_ON;
          else if (cnt == FORCE_LAST) state_d = ST_LS_ON;
          else begin
            cnt_clr = 1'b0;
            cnt_en  = 1'b1;
          end
        end
        ST_LS_ON: begin
          if (pwm_s)                  state_d = ST_HS_WAIT;
          else if (sw_low_s)          state_d = ST_LS_ON;
          else if (cnt == STUCK_LAST) state_d = ST_PARK;
          else begin
            cnt_clr = 1'b0;
            cnt_en  = 1'b1;
          end
        end
        ST_PARK: begin
          if (pwm_rise) state_d = ST_HS_WAIT;
        end
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_OFF;
      pwm_q   <= 1'b0;
      hs_q    <= 1'b0;
      ls_q    <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pwm_q   <= pwm_s;
      hs_q    <= (state_d == ST_HS_ON);
      ls_q    <= (state_d == ST_LS_ON);
      if (state_q == ST_LS_ON && state_d == ST_PARK) fault_q <= 1'b1;
      else if (pwm_rise)                             fault_q <= 1'b0;
    end
  end
endmodule

// File: rtl/halfbridge_deadtime_seq.sv
module halfbridge_deadtime_seq
  import hbs_pkg::*;
#(
  parameter int CLK_MHZ     = 100,
  parameter int FORCE_NS    = 250,
  parameter int STUCK_NS    = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pwm_in,
  input  logic shdn_in,
  input  logic vcc_rise_in,
  input  logic vcc_fall_in,
  input  logic lg_low_in,
  input  logic sw_low_in,
  output logic hs_gate_en,
  output logic ls_gate_en,
  output logic stuck_fault
);
  localparam int FORCE_CYC = int'(ns_to_cycles(CLK_MHZ, FORCE_NS));
  localparam int STUCK_CYC = int'(ns_to_cycles(CLK_MHZ, STUCK_NS));
  localparam int LONGEST   = (FORCE_CYC > STUCK_CYC) ? FORCE_CYC : STUCK_CYC;
  localparam int CNT_W     = $clog2(LONGEST + 1);

  logic [NUM_IN-1:0] raw_in, sync_in;
  logic pwm_s, shdn_s, vrise_s, vfall_s, lg_low_s, sw_low_s;
  logic pgood_q;
  logic run_en;

  always_comb begin
    raw_in            = '0;
    raw_in[IDX_PWM]   = pwm_in;
    raw_in[IDX_SHDN]  = shdn_in;
    raw_in[IDX_VRISE] = vcc_rise_in;
    raw_in[IDX_VFALL] = vcc_fall_in;
    raw_in[IDX_LGLOW] = lg_low_in;
    raw_in[IDX_SWLOW] = sw_low_in;
  end

  hbs_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) in_sync_i (
    .clk(clk), .rst(rst), .d(raw_in), .q(sync_in)
  );

  assign pwm_s    = sync_in[IDX_PWM];
  assign shdn_s   = sync_in[IDX_SHDN];
  assign vrise_s  = sync_in[IDX_VRISE];
  assign vfall_s  = sync_in[IDX_VFALL];
  assign lg_low_s = sync_in[IDX_LGLOW];
  assign sw_low_s = sync_in[IDX_SWLOW];

  hbs_supply_mon supply_i (
    .clk(clk), .rst(rst), .rise_s(vrise_s), .fall_s(vfall_s), .good_q(pgood_q)
  );

  assign run_en = pgood_q & ~shdn_s;

  hbs_fsm #(
    .FORCE_CYC(FORCE_CYC), .STUCK_CYC(STUCK_CYC), .CNT_W(CNT_W)
  ) seq_i (
    .clk(clk), .rst(rst), .enable(run_en),
    .pwm_s(pwm_s), .lg_low_s(lg_low_s), .sw_low_s(sw_low_s),
    .hs_q(hs_gate_en), .ls_q(ls_gate_en), .fault_q(stuck_fault)
  );
endmodule

// File: rtl/hbs_chk.sv
module hbs_chk (
  input logic clk,
  input logic rst,
  input logic hs_en,
  input logic ls_en,
  input logic fault,
  input logic shdn_s,
  input logic pgood,
  input logic lg_low_s
);
  // R2
  never_both_on_chk: assert property (@(posedge clk) disable iff (rst)
    !(hs_en && ls_en));

  // R3
  hs_after_lg_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_en) |-> ($past(lg_low_s) && !$past(ls_en)));

  // R9
  shdn_forces_off_chk: assert property (@(posedge clk) disable iff (rst)
    shdn_s |=> (!hs_en && !ls_en));

  // R8
  no_supply_off_chk: assert property (@(posedge clk) disable iff (rst)
    !pgood |=> (!hs_en && !ls_en));

  // R6
  fault_drops_ls_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fault) |-> $fell(ls_en));

  // R7
  fault_parks_chk: assert property (@(posedge clk) disable iff (rst)
    fault |-> (!hs_en && !ls_en));
endmodule

bind halfbridge_deadtime_seq hbs_chk chk_i (
  .clk(clk), .rst(rst), .hs_en(hs_gate_en), .ls_en(ls_gate_en),
  .fault(stuck_fault), .shdn_s(shdn_s), .pgood(pgood_q), .lg_low_s(lg_low_s)
);

// File: tb/halfbridge_deadtime_seq_tb_top.sv
`timescale 1ns/1ps
module halfbridge_deadtime_seq_tb_top;
  localparam int FORCE = (100 * 250 + 999) / 1000;   // 25
  localparam int STUCK = (100 * 2000 + 999) / 1000;  // 200

  logic clk = 1'b0;
  logic rst, pwm, shdn, vrise, vfall, lgl, swl;
  logic hs, ls, flt;
  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  halfbridge_deadtime_seq dut_i (
    .clk(clk), .rst(rst), .pwm_in(pwm), .shdn_in(shdn),
    .vcc_rise_in(vrise), .vcc_fall_in(vfall), .lg_low_in(lgl),
    .sw_low_in(swl), .hs_gate_en(hs), .ls_gate_en(ls), .stuck_fault(flt)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic sel(input int w);
    case (w)
      0: return hs;
      1: return ls;
      default: return flt;
    endcase
  endfunction

  task automatic wait_for(input int w, input logic val, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (sel(w) !== val && n < 1000);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // R2 invariant at the ports
  always @(negedge clk) begin
    if (!rst && hs && ls) begin
      tests++; fails++;
      $display("FAIL R2 actual=both_on expected=at_most_one");
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    int n, g, expv, c;
    rst = 1; pwm = 0; shdn = 0; vrise = 0; vfall = 0; lgl = 0; swl = 0;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 hs", hs, 0); chk("R1 ls", ls, 0); chk("R1 fault", flt, 0);

    // R8: no supply-good yet, PWM high must do nothing
    pwm = 1; lgl = 1; swl = 1;
    repeat (12) @(negedge clk);
    chk("R8 hs before good", hs, 0); chk("R8 ls before good", ls, 0);
    vrise = 1; @(negedge clk); vrise = 0;
    wait_for(0, 1'b1, n);
    chk("R8 start latency", n, 4);
    repeat (20) @(negedge clk);
    chk("R8 good held", hs, 1);
    swl = 0;

    // sweep of switch-node and gate flag delays (R3 R4 R5 R10)
    for (int k = 0; k <= 26; k++) begin
      int j;
      j = k % 9;
      pwm = 0;
      wait_for(0, 1'b0, n);
      chk("R10 hs off latency", n, 3);
      chk("R4 ls still off", ls, 0);
      g = 0;
      if (k == 0) swl = 1;
      do begin
        @(negedge clk);
        g++;
        if (!ls && g == k) swl = 1;
      end while (!ls && g < 100);
      expv = (k + 3 < FORCE) ? k + 3 : FORCE;
      if (k + 3 < FORCE) chk("R4 ls on after sw low", g, expv);
      else               chk("R5 ls forced on", g, expv);
      swl = 1; lgl = 0; pwm = 1;
      wait_for(1, 1'b0, n);
      chk("R10 ls off latency", n, 3);
      chk("R3 hs waits", hs, 0);
      g = 0;
      if (j == 0) lgl = 1;
      do begin
        @(negedge clk);
        g++;
        if (!hs && g == j) lgl = 1;
      end while (!hs && g < 100);
      chk("R3 hs on after lg low", g, j + 3);
      swl = 0;
    end

    // R6 near miss: one sample of sw low restarts the count
    pwm = 0;
    wait_for(1, 1'b1, n);
    chk("R5 forced from hs on", n, 3 + FORCE);
    repeat (150) @(negedge clk);
    swl = 1; @(negedge clk); swl = 0;
    repeat (150) @(negedge clk);
    chk("R6 restart ls", ls, 1); chk("R6 restart fault", flt, 0);
    repeat (100) @(negedge clk);
    chk("R6 late park ls", ls, 0); chk("R6 late park fault", flt, 1);

    // R7: parked ignores sw low, clears on PWM rise
    swl = 1;
    repeat (30) @(negedge clk);
    chk("R7 parked hs", hs, 0); chk("R7 parked ls", ls, 0);
    chk("R7 parked fault", flt, 1);
    swl = 0; lgl = 1; pwm = 1;
    wait_for(2, 1'b0, n);
    chk("R7 fault clear latency", n, 3);
    @(negedge clk);
    chk("R7 hs resumes", hs, 1);

    // R6 exact window
    pwm = 0;
    wait_for(1, 1'b1, n);
    chk("R5 forced again", n, 3 + FORCE);
    c = 0;
    do begin
      @(negedge clk);
      c++;
    end while (ls && c < 1000);
    chk("R6 ls on length", c, STUCK);
    chk("R6 fault set", flt, 1); chk("R6 hs off", hs, 0);
    pwm = 1;
    wait_for(0, 1'b1, n);
    chk("R7 resume latency", n, 4);
    chk("R7 fault cleared", flt, 0);

    // R9 shutdown
    shdn = 1;
    wait_for(0, 1'b0, n);
    chk("R9 hs off latency", n, 3);
    pwm = 0; swl = 1;
    repeat (20) @(negedge clk);
    chk("R9 hs held", hs, 0); chk("R9 ls held", ls, 0);
    shdn = 0;
    wait_for(1, 1'b1, n);
    chk("R9 resume latency", n, 4);

    // R8 supply loss and return
    lgl = 0;
    vfall = 1; @(negedge clk); vfall = 0;
    wait_for(1, 1'b0, n);
    chk("R8 fall latency", n, 3);
    repeat (20) @(negedge clk);
    chk("R8 held off ls", ls, 0); chk("R8 held off hs", hs, 0);
    vrise = 1; @(negedge clk); vrise = 0;
    wait_for(1, 1'b1, n);
    chk("R8 return latency", n, 4);

    summary();
  end
endmodule